// File: doc/BRIEF.md
# I2C Serial Memory Target

This block is an I2C target that stands in front of a byte-wide internal memory of 4096 locations. It runs entirely from a synchronous system clock. It oversamples the bus clock and data lines through two-flop synchronizers and pulls the data line low through an output-enable signal, so the pad is used as an open-drain output. Every transfer begins with a control byte. Its top four bits are a fixed device code, the next three must match the static chip-select inputs, and its last bit selects read (1) or write (0).

A write carries a two-byte word address, high byte first, followed by any number of data bytes. A single address pointer is shared by reads and writes and keeps its value from one transaction to the next. Three kinds of read use it:

- A read control byte with no address phase returns the byte at the pointer.
- A write control byte plus address, followed by a repeated start, positions the pointer for a random read.
- A master that acknowledges each returned byte receives consecutive locations, wrapping across the whole array.

Top module: `i2c_mem_target`

## Requirements
- R1: The target acknowledges a control byte only when its bits 7..4 equal 1010 and its bits 3..1 equal `chip_sel`. On a mismatch it leaves SDA released for that byte and every later byte, and it changes neither memory nor pointer until the next start.
- R2: A start (SDA falling while SCL is high) or a stop (SDA rising while SCL is high) ends any transfer in progress. A byte that is cut short this way is neither stored nor acknowledged.
- R3: The target changes its SDA drive only while SCL is low. An acknowledge is SDA held low for the whole ninth clock.
- R4: After a write control byte, two address bytes are accepted, high byte first, and each is acknowledged. The upper 4 bits of the high byte are ignored.
- R5: Each data byte after the address is stored at the pointer and acknowledged. The pointer then increments, wrapping from 0xFFF to 0x000.
- R6: A read control byte with no preceding address phase returns the byte at the pointer, that is, the location after the last one accessed.
- R7: A write control byte plus address, followed by a repeated start and a read control byte, returns the byte at that address.
- R8: When the master acknowledges a returned byte, the next location is sent. Reading past 0xFFF continues at 0x000.
- R9: After the master's no-acknowledge, the target keeps SDA released until the next start. The pointer is left at the location after the last byte sent.
- R10: Data bits are sent and received most significant bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| chip_sel | input | 3 | Static chip-select strap compared against control bits 3..1 |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Because the pointer persists, a pointer that increments wrongly or loads the wrong address byte shows up as a wrong data value on the very next read. This happens even in a later transaction that carries no address, so every read is scored against a model of the pointer. A mis-set bit counter or state appears within one byte as a missing or misplaced acknowledge, or as a byte that is shifted by one position. An SDA edge that occurs while SCL is high is caught by a bench monitor, because such an edge would look to the bus like a start or a stop.

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
  parameter int          ADDR_W   = 12,
  parameter logic [3:0]  DEV_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] chip_sel,
  output logic       sda_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 8;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} st_t;
  typedef enum logic [1:0] {K_CTRL, K_AHI, K_ALO, K_DATA} kind_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  st_t        st;
  kind_t      kind;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic       rd, mack;
  logic [HI_W-1:0]   addr_hi;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        mem [DEPTH];

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire quiet    = ~start_c & ~stop_c;
  wire byte_end = quiet & (st == S_RX) & scl_fall & (cnt == 4'd8);
  wire ctrl_ok  = sh[7:1] == {DEV_CODE, chip_sel};
  wire mem_we   = byte_end & (kind == K_DATA);
  wire [7:0] rdata = mem[ptr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i}; sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_s;              sda_d  <= sda_s;
    end

  always_ff @(posedge clk)
    if (mem_we) mem[ptr] <= sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_CTRL; cnt <= '0; sh <= '0; tx <= '0;
      rd <= 1'b0; mack <= 1'b0; addr_hi <= '0; ptr <= '0; sda_oe <= 1'b0;
    end else if (start_c) begin
      st <= S_RX; kind <= K_CTRL; cnt <= '0; sda_oe <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; sda_oe <= 1'b0;
    end else begin
      case (st)
        S_RX:
          if (scl_rise && cnt != 4'd8) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (byte_end) begin
            st <= S_ACK; sda_oe <= 1'b1;
            case (kind)
              K_CTRL: if (ctrl_ok) rd <= sh[0];
                      else begin st <= S_IDLE; sda_oe <= 1'b0; end
              K_AHI:  addr_hi <= sh[HI_W-1:0];
              K_ALO:  ptr <= {addr_hi, sh};
              default: ptr <= ptr + 1'b1;
            endcase
          end
        S_ACK:
          if (scl_fall) begin
            cnt <= '0;
            if (kind == K_CTRL && rd) begin
              tx <= rdata; sda_oe <= ~rdata[7]; st <= S_TX;
            end else begin
              sda_oe <= 1'b0; st <= S_RX;
              kind <= (kind == K_CTRL) ? K_AHI : (kind == K_AHI) ? K_ALO : K_DATA;
            end
          end
        S_TX:
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_oe <= 1'b0; st <= S_MACK; ptr <= ptr + 1'b1;
            end else begin
              cnt <= cnt + 4'd1; tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6];
            end
          end
        S_MACK:
          if (scl_rise) mack <= ~sda_s;
          else if (scl_fall) begin
            if (mack) begin
              tx <= rdata; sda_oe <= ~rdata[7]; cnt <= '0; st <= S_TX;
            end else st <= S_IDLE;
          end
        default: sda_oe <= 1'b0;
      endcase
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe); // R1
  AST_BAD_CTRL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && kind == K_CTRL && !ctrl_ok) |=> (st == S_IDLE && !sda_oe)); // R1
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s); // R3
  AST_WRITE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (ptr == $past(ptr) + 1'b1)); // R5
  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && st == S_TX && scl_fall && cnt == 4'd7) |=> (ptr == $past(ptr) + 1'b1)); // R8
  AST_MACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MACK) |-> !sda_oe); // R9
endmodule

// File: tb/i2c_mem_target_tb_top.sv
`timescale 1ns/1ps
module i2c_mem_target_tb_top;
  localparam int Q = 10;
  localparam logic [7:0] CW = 8'hAA, CR = 8'hAB;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0;
  logic sda_oe;
  wire  sda = !(m_low || sda_oe);
  int total = 0, fails = 0, viol = 0;
  logic [7:0] exp_q[$], act_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  i2c_mem_target dut_i (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
                        .chip_sel(3'b101), .sda_oe(sda_oe));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0) begin
      logic [7:0] a, e;
      string t;
      a = act_q.pop_front();
      if (exp_q.size() == 0) chk(1'b0, "R6", "unexpected byte", a, 0);
      else begin
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(a == e, t, "read data", a, e);
      end
    end
  end

  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe != prev_oe && scl) viol++;
    prev_oe <= sda_oe;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R2", "watchdog", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic send_bit(input bit b);
    m_low = !b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask
  task automatic get_bit(output bit b);
    m_low = 1'b0; wq(); scl = 1'b1; wq(); b = sda; wq(); scl = 1'b0; wq();
  endtask
  task automatic bus_start();
    m_low = 1'b0; wq(); scl = 1'b1; wq(); m_low = 1'b1; wq(); scl = 1'b0; wq();
  endtask
  task automatic bus_stop();
    m_low = 1'b1; wq(); scl = 1'b1; wq(); m_low = 1'b0; wq();
  endtask
  task automatic send_byte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    get_bit(b); ack = !b;
  endtask
  task automatic send_chk(input logic [7:0] d, input bit want, input string req);
    bit ack;
    send_byte(d, ack);
    chk(ack == want, req, "acknowledge", ack, want);
  endtask
  task automatic rd_exp(input logic [7:0] e, input bit mack, input string req);
    logic [7:0] d;
    bit b;
    exp_q.push_back(e); tag_q.push_back(req);
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    act_q.push_back(d);
    send_bit(!mack);
    m_low = 1'b0;
  endtask
  task automatic addr_phase(input logic [15:0] a);
    bus_start(); send_chk(CW, 1'b1, "R1"); send_chk(a[15:8], 1'b1, "R4");
    send_chk(a[7:0], 1'b1, "R4");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R2", "reset release", sda_oe, 0);
    rst_n = 1'b1; wq();
    // R4: upper nibble of the high address byte is ignored -> 0x123
    addr_phase(16'hF123);
    send_chk(8'hA5, 1'b1, "R5"); send_chk(8'h3C, 1'b1, "R5");
    send_chk(8'h96, 1'b1, "R5"); send_chk(8'h5A, 1'b1, "R5");
    send_chk(8'hC3, 1'b1, "R5");
    bus_stop();
    // R7 random read, R8 sequential, R10 bit order
    addr_phase(16'h0123); bus_start(); send_chk(CR, 1'b1, "R7");
    rd_exp(8'hA5, 1'b1, "R7"); rd_exp(8'h3C, 1'b1, "R8"); rd_exp(8'h96, 1'b0, "R10");
    chk(sda_oe == 1'b0, "R9", "released after no-ack", sda_oe, 0);
    bus_stop();
    // R6 current-address read continues after 0x125
    bus_start(); send_chk(CR, 1'b1, "R6"); rd_exp(8'h5A, 1'b0, "R6"); bus_stop();
    // R1 wrong chip select, then pointer still at 0x127
    bus_start(); send_chk(8'hA2, 1'b0, "R1"); send_chk(8'h00, 1'b0, "R1");
    send_chk(8'h77, 1'b0, "R1"); bus_stop();
    bus_start(); send_chk(8'hA3, 1'b0, "R1"); bus_stop();
    bus_start(); send_chk(CR, 1'b1, "R1"); rd_exp(8'hC3, 1'b0, "R1"); bus_stop();
    // R5 write wrap, R8 read wrap, R9 pointer after read
    addr_phase(16'h0FFF);
    send_chk(8'h11, 1'b1, "R5"); send_chk(8'h22, 1'b1, "R5"); send_chk(8'h33, 1'b1, "R5");
    bus_stop();
    addr_phase(16'h0FFF); bus_start(); send_chk(CR, 1'b1, "R7");
    rd_exp(8'h11, 1'b1, "R8"); rd_exp(8'h22, 1'b0, "R8"); bus_stop();
    bus_start(); send_chk(CR, 1'b1, "R9"); rd_exp(8'h33, 1'b0, "R9"); bus_stop();
    // R2 partial byte cut short by stop is not stored
    addr_phase(16'h0300); send_chk(8'h44, 1'b1, "R5"); bus_stop();
    addr_phase(16'h0300);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    chk(sda_oe == 1'b0, "R2", "released after stop", sda_oe, 0);
    addr_phase(16'h0300); bus_start(); send_chk(CR, 1'b1, "R7");
    rd_exp(8'h44, 1'b0, "R2"); bus_stop();
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R6", "scoreboard drained", exp_q.size(), 0);
    chk(viol == 0, "R3", "SDA edges while SCL high", viol, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule